// File: doc/BRIEF.md
# Variable-Length Instruction Operand Decoder

This block looks at a 16-bit opcode parcel and the parcels that follow it, and works out three things: how many bytes the instruction occupies, what its immediate value is, and what effective address its addressing mode yields. It sits between instruction fetch and execute. Fetch presents the opcode, up to three extension parcels and the address of the opcode. The decoder names two general-register indices on a pair of read ports, the register file answers in the same cycle, and the decoded operands come out registered one cycle later.

Extension parcels are numbered in fetch order. Parcel one sits at PC+2, parcel two at PC+4 and parcel three at PC+6. A 32-bit quantity is little-endian across two parcels, so its low half is the earlier parcel. Formats are recognised in a fixed priority order: immediate, then complex addressing, then extended-operation (macro), and otherwise a short 2-byte form.

Top module: `opdec_operand_unit`

## Requirements
- R1: While `rst_n` is low, `res_valid` is 0 and every result output reads 0.
- R2: `res_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, every result output holds its last value.
- R3: An opcode carries an immediate when `(opcode & 0xF800) == 0x3800` or `(opcode & 0xD300) == 0x8300`. It then reports `res_kind` = 1. When opcode bit 7 is set, `res_imm` is parcel one sign-extended and `res_len` is 4.
- R4: For an immediate opcode with bit 7 clear, `res_imm` is {parcel two, parcel one} and `res_len` is 6.
- R5: Complex addressing applies when `(opcode & 0xF100) == 0x4100` or `(opcode & 0xE100) == 0x6100`, and reports `res_kind` = 2 with the mode taken from opcode bits 7:4. Mode 0x1 gives `res_ea` = PC + {parcel two, parcel one}. Mode 0x3 gives `res_ea` = {parcel two, parcel one}. Both modes have length 6 and take `res_reg` from opcode bits 3:0.
- R6: Mode 0x6 gives `res_ea` = base register (opcode bits 3:0) + {parcel three, parcel two}, with length 8 and `res_reg` from parcel one bits 3:0.
- R7: Mode 0xA gives `res_ea` = base register + (parcel one bits 15:4, sign-extended), with length 4 and `res_reg` from parcel one bits 3:0.
- R8: Mode 0x9 gives `res_ea` = PC + sign-extended parcel one. Mode 0xB gives `res_ea` = sign-extended parcel one. Both have length 4 and take `res_reg` from opcode bits 3:0.
- R9: Mode 0xD gives `res_ea` = PC + index register. Mode 0xE gives `res_ea` = base register + index register. The index register is named by parcel one bits 7:4. Both have length 4 and take `res_reg` from parcel one bits 3:0.
- R10: A non-immediate, non-complex opcode with `(opcode & 0xFD00) == 0xB400` reports `res_kind` = 3, `res_len` = 4, `res_imm` = parcel one zero-extended and `res_ea` = 0.
- R11: Every other opcode reports `res_kind` = 0, `res_len` = 2 and zero immediate and address, with `res_reg` from opcode bits 3:0. Non-addressing formats always report `res_ea` = 0, and non-immediate formats other than macro report `res_imm` = 0.
- R12: A complex opcode whose mode is not one of 0x1, 0x3, 0x6, 0x9, 0xA, 0xB, 0xD, 0xE raises `res_illegal`, reports length 2 and `res_ea` = 0, and takes `res_reg` from opcode bits 3:0.
- R13: `base_idx` always equals opcode bits 3:0 and `index_idx` always equals parcel one bits 7:4, in the same cycle and without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Opcode and parcels are valid this cycle |
| opcode | input | 16 | Opcode parcel |
| ext1 | input | 16 | First extension parcel (PC+2) |
| ext2 | input | 16 | Second extension parcel (PC+4) |
| ext3 | input | 16 | Third extension parcel (PC+6) |
| pc | input | ADDR_W | Address of the opcode parcel |
| base_idx | output | 4 | Register index for the base read port |
| index_idx | output | 4 | Register index for the index read port |
| base_data | input | ADDR_W | Register file contents at `base_idx` |
| index_data | input | ADDR_W | Register file contents at `index_idx` |
| res_valid | output | 1 | Result outputs carry a new decode |
| res_len | output | 4 | Instruction length in bytes |
| res_imm | output | ADDR_W | Immediate or macro parcel |
| res_ea | output | ADDR_W | Effective address |
| res_reg | output | 4 | Selected data register index |
| res_kind | output | 2 | Format: 0 short, 1 immediate, 2 addressing, 3 macro |
| res_illegal | output | 1 | Undefined addressing mode |

## Verification
The register indices are combinational, so they are due in the same cycle as the opcode that names them. Every decoded result is due exactly one rising edge after it is presented with `in_valid`. The bench drives each stimulus on a falling edge and predicts its result with a behavioural model. At the next falling edge it compares the register indices against the inputs still being driven and the registered results against the prediction. On idle cycles the same comparison confirms that the previous result is still held.

// File: rtl/opdec_pkg.sv
package opdec_pkg;

  localparam int unsigned PARCEL_W = 16;
  localparam int unsigned RIDX_W   = 4;
  localparam int unsigned LEN_W    = 4;

  typedef enum logic [1:0] {
    FMT_PLAIN = 2'd0,
    FMT_IMM   = 2'd1,
    FMT_ADDR  = 2'd2,
    FMT_MACRO = 2'd3
  } fmt_e;

  // addressing mode codes held in opcode bits 7:4
  localparam logic [3:0] MODE_PC_D32  = 4'h1;
  localparam logic [3:0] MODE_ABS_32  = 4'h3;
  localparam logic [3:0] MODE_REG_D32 = 4'h6;
  localparam logic [3:0] MODE_PC_D16  = 4'h9;
  localparam logic [3:0] MODE_REG_D12 = 4'hA;
  localparam logic [3:0] MODE_ABS_16  = 4'hB;
  localparam logic [3:0] MODE_PC_IDX  = 4'hD;
  localparam logic [3:0] MODE_REG_IDX = 4'hE;

  function automatic logic field_match(input logic [PARCEL_W-1:0] word,
                                       input logic [PARCEL_W-1:0] mask,
                                       input logic [PARCEL_W-1:0] pattern);
    return (word & mask) == pattern;
  endfunction

endpackage

// File: rtl/opdec_format_sel.sv
module opdec_format_sel
  import opdec_pkg::*;
(
  input  logic [PARCEL_W-1:0] opcode_i,
  output fmt_e                fmt_o,
  output logic                imm_short_o
);

  logic has_imm;
  logic has_ea;
  logic has_macro;

  assign has_imm   = field_match(opcode_i, 16'hF800, 16'h3800) ||
                     field_match(opcode_i, 16'hD300, 16'h8300);
  assign has_ea    = field_match(opcode_i, 16'hF100, 16'h4100) ||
                     field_match(opcode_i, 16'hE100, 16'h6100);
  assign has_macro = field_match(opcode_i, 16'hFD00, 16'hB400);

  // priority: immediate, addressing, macro, short
  always_comb begin
    if (has_imm)        fmt_o = FMT_IMM;
    else if (has_ea)    fmt_o = FMT_ADDR;
    else if (has_macro) fmt_o = FMT_MACRO;
    else                fmt_o = FMT_PLAIN;
  end

  assign imm_short_o = opcode_i[7];

endmodule

// File: rtl/opdec_imm_extract.sv
module opdec_imm_extract
  import opdec_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  fmt_e                fmt_i,
  input  logic                short_i,
  input  logic [PARCEL_W-1:0] ext1_i,
  input  logic [PARCEL_W-1:0] ext2_i,
  output logic [ADDR_W-1:0]   imm_o,
  output logic [LEN_W-1:0]    len_o
);

  logic signed [PARCEL_W-1:0]   half_s;
  logic signed [2*PARCEL_W-1:0] word_s;

  assign half_s = $signed(ext1_i);
  assign word_s = $signed({ext2_i, ext1_i});

  always_comb begin
    imm_o = '0;
    len_o = LEN_W'(2);
    case (fmt_i)
      FMT_IMM: begin
        if (short_i) begin
          imm_o = ADDR_W'(half_s);
          len_o = LEN_W'(4);
        end else begin
          imm_o = ADDR_W'(word_s);
          len_o = LEN_W'(6);
        end
      end
      FMT_MACRO: begin
        imm_o = ADDR_W'(ext1_i);
        len_o = LEN_W'(4);
      end
      default: begin
        imm_o = '0;
        len_o = LEN_W'(2);
      end
    endcase
  end

endmodule

// File: rtl/opdec_addr_mode.sv
module opdec_addr_mode
  import opdec_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [3:0]          mode_i,
  input  logic [RIDX_W-1:0]   opreg_i,
  input  logic [PARCEL_W-1:0] ext1_i,
  input  logic [PARCEL_W-1:0] ext2_i,
  input  logic [PARCEL_W-1:0] ext3_i,
  input  logic [ADDR_W-1:0]   pc_i,
  input  logic [ADDR_W-1:0]   base_data_i,
  input  logic [ADDR_W-1:0]   index_data_i,
  output logic [ADDR_W-1:0]   ea_o,
  output logic [RIDX_W-1:0]   data_reg_o,
  output logic [LEN_W-1:0]    len_o,
  output logic                illegal_o
);

  localparam int unsigned D12_W = PARCEL_W - RIDX_W;

  logic signed [PARCEL_W-1:0]   d16_s;
  logic signed [D12_W-1:0]      d12_s;
  logic signed [2*PARCEL_W-1:0] d32_near_s;
  logic signed [2*PARCEL_W-1:0] d32_far_s;
  logic [ADDR_W-1:0]            d16_x;
  logic [ADDR_W-1:0]            d12_x;
  logic [ADDR_W-1:0]            d32_near_x;
  logic [ADDR_W-1:0]            d32_far_x;
  logic [RIDX_W-1:0]            split_reg;

  assign d16_s      = $signed(ext1_i);
  assign d12_s      = $signed(ext1_i[PARCEL_W-1:RIDX_W]);
  assign d32_near_s = $signed({ext2_i, ext1_i});
  assign d32_far_s  = $signed({ext3_i, ext2_i});
  assign d16_x      = ADDR_W'(d16_s);
  assign d12_x      = ADDR_W'(d12_s);
  assign d32_near_x = ADDR_W'(d32_near_s);
  assign d32_far_x  = ADDR_W'(d32_far_s);
  assign split_reg  = ext1_i[RIDX_W-1:0];

  always_comb begin
    ea_o       = '0;
    data_reg_o = opreg_i;
    len_o      = LEN_W'(2);
    illegal_o  = 1'b0;
    case (mode_i)
      MODE_PC_D32: begin
        ea_o  = pc_i + d32_near_x;
        len_o = LEN_W'(6);
      end
      MODE_ABS_32: begin
        ea_o  = d32_near_x;
        len_o = LEN_W'(6);
      end
      MODE_REG_D32: begin
        ea_o       = base_data_i + d32_far_x;
        data_reg_o = split_reg;
        len_o      = LEN_W'(8);
      end
      MODE_PC_D16: begin
        ea_o  = pc_i + d16_x;
        len_o = LEN_W'(4);
      end
      MODE_REG_D12: begin
        ea_o       = base_data_i + d12_x;
        data_reg_o = split_reg;
        len_o      = LEN_W'(4);
      end
      MODE_ABS_16: begin
        ea_o  = d16_x;
        len_o = LEN_W'(4);
      end
      MODE_PC_IDX: begin
        ea_o       = pc_i + index_data_i;
        data_reg_o = split_reg;
        len_o      = LEN_W'(4);
      end
      MODE_REG_IDX: begin
        ea_o       = base_data_i + index_data_i;
        data_reg_o = split_reg;
        len_o      = LEN_W'(4);
      end
      default: begin
        illegal_o = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/opdec_operand_unit.sv
module opdec_operand_unit
  import opdec_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [PARCEL_W-1:0] opcode,
  input  logic [PARCEL_W-1:0] ext1,
  input  logic [PARCEL_W-1:0] ext2,
  input  logic [PARCEL_W-1:0] ext3,
  input  logic [ADDR_W-1:0]   pc,
  output logic [RIDX_W-1:0]   base_idx,
  output logic [RIDX_W-1:0]   index_idx,
  input  logic [ADDR_W-1:0]   base_data,
  input  logic [ADDR_W-1:0]   index_data,
  output logic                res_valid,
  output logic [LEN_W-1:0]    res_len,
  output logic [ADDR_W-1:0]   res_imm,
  output logic [ADDR_W-1:0]   res_ea,
  output logic [RIDX_W-1:0]   res_reg,
  output logic [1:0]          res_kind,
  output logic                res_illegal
);

  fmt_e              fmt;
  logic              imm_short;
  logic [ADDR_W-1:0] imm_val;
  logic [LEN_W-1:0]  imm_len;
  logic [ADDR_W-1:0] am_ea;
  logic [RIDX_W-1:0] am_reg;
  logic [LEN_W-1:0]  am_len;
  logic              am_illegal;

  logic              valid_q, valid_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [ADDR_W-1:0] imm_q, imm_d;
  logic [ADDR_W-1:0] ea_q, ea_d;
  logic [RIDX_W-1:0] reg_q, reg_d;
  logic [1:0]        kind_q, kind_d;
  logic              ill_q, ill_d;

  // register read ports: base from opcode, index from first parcel
  assign base_idx  = opcode[RIDX_W-1:0];
  assign index_idx = ext1[2*RIDX_W-1:RIDX_W];

  opdec_format_sel u_fmt (
    .opcode_i    (opcode),
    .fmt_o       (fmt),
    .imm_short_o (imm_short)
  );

  opdec_imm_extract #(.ADDR_W(ADDR_W)) u_imm (
    .fmt_i   (fmt),
    .short_i (imm_short),
    .ext1_i  (ext1),
    .ext2_i  (ext2),
    .imm_o   (imm_val),
    .len_o   (imm_len)
  );

  opdec_addr_mode #(.ADDR_W(ADDR_W)) u_am (
    .mode_i       (opcode[7:4]),
    .opreg_i      (opcode[RIDX_W-1:0]),
    .ext1_i       (ext1),
    .ext2_i       (ext2),
    .ext3_i       (ext3),
    .pc_i         (pc),
    .base_data_i  (base_data),
    .index_data_i (index_data),
    .ea_o         (am_ea),
    .data_reg_o   (am_reg),
    .len_o        (am_len),
    .illegal_o    (am_illegal)
  );

  // next-state: load on in_valid, otherwise hold
  always_comb begin
    valid_d = in_valid;
    len_d   = len_q;
    imm_d   = imm_q;
    ea_d    = ea_q;
    reg_d   = reg_q;
    kind_d  = kind_q;
    ill_d   = ill_q;
    if (in_valid) begin
      kind_d = fmt;
      imm_d  = imm_val;
      if (fmt == FMT_ADDR) begin
        len_d = am_len;
        ea_d  = am_ea;
        reg_d = am_reg;
        ill_d = am_illegal;
      end else begin
        len_d = imm_len;
        ea_d  = '0;
        reg_d = opcode[RIDX_W-1:0];
        ill_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      len_q   <= '0;
      imm_q   <= '0;
      ea_q    <= '0;
      reg_q   <= '0;
      kind_q  <= '0;
      ill_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      len_q   <= len_d;
      imm_q   <= imm_d;
      ea_q    <= ea_d;
      reg_q   <= reg_d;
      kind_q  <= kind_d;
      ill_q   <= ill_d;
    end
  end

  assign res_valid   = valid_q;
  assign res_len     = len_q;
  assign res_imm     = imm_q;
  assign res_ea      = ea_q;
  assign res_reg     = reg_q;
  assign res_kind    = kind_q;
  assign res_illegal = ill_q;

endmodule

// File: rtl/opdec_operand_chk.sv
module opdec_operand_chk
  import opdec_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              res_valid,
  input logic [LEN_W-1:0]  res_len,
  input logic [ADDR_W-1:0] res_imm,
  input logic [ADDR_W-1:0] res_ea,
  input logic [1:0]        res_kind,
  input logic              res_illegal
);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> !res_valid);

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(res_ea) && $stable(res_imm) && $stable(res_len) && $stable(res_kind)));

  p_imm_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == FMT_IMM) |-> ((res_len == 4 || res_len == 6) && res_ea == '0));

  p_addr_no_imm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == FMT_ADDR) |-> (res_imm == '0 && res_len >= 2 && res_len <= 8 && !res_len[0]));

  p_macro_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == FMT_MACRO) |-> (res_len == 4 && res_ea == '0));

  p_plain_len_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_kind == FMT_PLAIN) |-> (res_len == 2 && res_imm == '0 && res_ea == '0));

  p_illegal_len_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_illegal) |-> (res_len == 2 && res_kind == FMT_ADDR && res_ea == '0));

endmodule

bind opdec_operand_unit opdec_operand_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .res_valid   (res_valid),
  .res_len     (res_len),
  .res_imm     (res_imm),
  .res_ea      (res_ea),
  .res_kind    (res_kind),
  .res_illegal (res_illegal)
);

// File: tb/opdec_operand_unit_tb_top.sv
module opdec_operand_unit_tb_top;

  localparam int ADDR_W = 32;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              in_valid;
  logic [15:0]       opcode, ext1, ext2, ext3;
  logic [ADDR_W-1:0] pc;
  logic [3:0]        base_idx, index_idx;
  logic [ADDR_W-1:0] base_data, index_data;
  logic              res_valid;
  logic [3:0]        res_len;
  logic [ADDR_W-1:0] res_imm, res_ea;
  logic [3:0]        res_reg;
  logic [1:0]        res_kind;
  logic              res_illegal;

  logic [31:0] rf [16];
  assign base_data  = rf[base_idx];
  assign index_data = rf[index_idx];

  opdec_operand_unit #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .opcode(opcode), .ext1(ext1), .ext2(ext2), .ext3(ext3), .pc(pc),
    .base_idx(base_idx), .index_idx(index_idx),
    .base_data(base_data), .index_data(index_data),
    .res_valid(res_valid), .res_len(res_len), .res_imm(res_imm),
    .res_ea(res_ea), .res_reg(res_reg), .res_kind(res_kind),
    .res_illegal(res_illegal)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // expectation for the registered outputs
  bit          pend_valid = 0;
  logic [31:0] x_len = 0, x_imm = 0, x_ea = 0, x_reg = 0, x_kind = 0, x_ill = 0;
  string       x_tag = "R1";

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx16(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  // behavioural reference
  task automatic model(input logic [15:0] op, e1, e2, e3, input logic [31:0] pcv);
    int m;
    x_len = 2; x_imm = 0; x_ea = 0; x_reg = {28'd0, op[3:0]}; x_kind = 0; x_ill = 0;
    if ((op & 16'hF800) == 16'h3800 || (op & 16'hD300) == 16'h8300) begin
      x_kind = 1;
      if (op[7]) begin x_imm = sx16(e1); x_len = 4; x_tag = "R3"; end
      else       begin x_imm = {e2, e1}; x_len = 6; x_tag = "R4"; end
    end else if ((op & 16'hF100) == 16'h4100 || (op & 16'hE100) == 16'h6100) begin
      x_kind = 2;
      m = int'(op[7:4]);
      case (m)
        1:  begin x_ea = pcv + {e2, e1}; x_len = 6; x_tag = "R5"; end
        3:  begin x_ea = {e2, e1}; x_len = 6; x_tag = "R5"; end
        6:  begin x_ea = rf[op[3:0]] + {e3, e2}; x_len = 8; x_reg = {28'd0, e1[3:0]}; x_tag = "R6"; end
        9:  begin x_ea = pcv + sx16(e1); x_len = 4; x_tag = "R8"; end
        10: begin x_ea = rf[op[3:0]] + (sx16(e1) >>> 4) | ((e1[15]) ? 32'hF000_0000 : 32'h0);
                  x_ea = rf[op[3:0]] + {{20{e1[15]}}, e1[15:4]};
                  x_len = 4; x_reg = {28'd0, e1[3:0]}; x_tag = "R7"; end
        11: begin x_ea = sx16(e1); x_len = 4; x_tag = "R8"; end
        13: begin x_ea = pcv + rf[e1[7:4]]; x_len = 4; x_reg = {28'd0, e1[3:0]}; x_tag = "R9"; end
        14: begin x_ea = rf[op[3:0]] + rf[e1[7:4]]; x_len = 4; x_reg = {28'd0, e1[3:0]}; x_tag = "R9"; end
        default: begin x_ill = 1; x_tag = "R12"; end
      endcase
    end else if ((op & 16'hFD00) == 16'hB400) begin
      x_kind = 3; x_len = 4; x_imm = {16'd0, e1}; x_tag = "R10";
    end else begin
      x_tag = "R11";
    end
  endtask

  task automatic compare_now();
    string t;
    check("R13", "base_idx", {28'd0, base_idx}, {28'd0, opcode[3:0]});
    check("R13", "index_idx", {28'd0, index_idx}, {28'd0, ext1[7:4]});
    check("R2", "res_valid", {31'd0, res_valid}, {31'd0, pend_valid});
    t = pend_valid ? x_tag : "R2";
    check(t, "res_len",     {28'd0, res_len},     x_len);
    check(t, "res_imm",     res_imm,              x_imm);
    check(t, "res_ea",      res_ea,               x_ea);
    check(t, "res_reg",     {28'd0, res_reg},     x_reg);
    check(t, "res_kind",    {30'd0, res_kind},    x_kind);
    check(t, "res_illegal", {31'd0, res_illegal}, x_ill);
  endtask

  task automatic step(input bit v, input logic [15:0] op, e1, e2, e3, input logic [31:0] pcv);
    @(negedge clk);
    compare_now();
    in_valid = v; opcode = op; ext1 = e1; ext2 = e2; ext3 = e3; pc = pcv;
    if (v) model(op, e1, e2, e3, pcv);
    pend_valid = v;
  endtask

  task automatic idle();
    step(1'b0, $urandom, $urandom, $urandom, $urandom, $urandom);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    opcode = 0; ext1 = 0; ext2 = 0; ext3 = 0; pc = 0;
    for (int i = 0; i < 16; i++) rf[i] = 32'h1000_0000 + i * 32'h0001_0111;
    rf[5]  = 32'hFFFF_FF00;
    rf[15] = 32'h8000_0004;
    repeat (3) @(negedge clk);
    check("R1", "res_valid in reset", {31'd0, res_valid}, 32'd0);
    check("R1", "res_ea in reset", res_ea, 32'd0);
    check("R1", "res_len in reset", {28'd0, res_len}, 32'd0);
    rst_n = 1'b1;

    // immediates
    step(1, 16'h3885, 16'h8001, 16'h0, 16'h0, 32'h4000);
    step(1, 16'h3805, 16'h1234, 16'hABCD, 16'h0, 32'h4000);
    step(1, 16'h8383, 16'h7FFF, 16'h1111, 16'h0, 32'h4000);
    step(1, 16'h8703, 16'h0002, 16'h8000, 16'h0, 32'h4000);
    idle();
    // addressing modes
    step(1, 16'h4912, 16'h0010, 16'h0000, 16'h0, 32'h4000);
    step(1, 16'h4912, 16'hFFFE, 16'hFFFF, 16'h0, 32'h4000);
    step(1, 16'h4937, 16'h5678, 16'h1234, 16'h0, 32'h4000);
    step(1, 16'h6163, 16'h0009, 16'h0100, 16'h0, 32'h4000);
    step(1, 16'h6165, 16'h000C, 16'hFFF0, 16'hFFFF, 32'h4000);
    step(1, 16'h4994, 16'h8000, 16'h0, 16'h0, 32'h4000);
    step(1, 16'h69A5, 16'hFFF7, 16'h0, 16'h0, 32'h4000);
    step(1, 16'h69A5, 16'h7FF2, 16'h0, 16'h0, 32'h4000);
    step(1, 16'h4BB1, 16'h9000, 16'h0, 16'h0, 32'h4000);
    step(1, 16'h49D0, 16'h0048, 16'h0, 16'h0, 32'h4000);
    step(1, 16'h69E2, 16'h00F3, 16'h0, 16'h0, 32'h4000);
    idle(); idle();
    // undefined modes
    step(1, 16'h4920, 16'h1234, 16'h0, 16'h0, 32'h4000);
    step(1, 16'h49F0, 16'h1234, 16'h0, 16'h0, 32'h4000);
    step(1, 16'h6107, 16'h1234, 16'h0, 16'h0, 32'h4000);
    // macro and short
    step(1, 16'hB405, 16'hBEEF, 16'h0, 16'h0, 32'h4000);
    step(1, 16'hB600, 16'h0042, 16'h0, 16'h0, 32'h4000);
    step(1, 16'h0000, 16'h5555, 16'h0, 16'h0, 32'h4000);
    step(1, 16'h4800, 16'h5555, 16'h0, 16'h0, 32'h4000);
    step(1, 16'h1234, 16'h5555, 16'h0, 16'h0, 32'h4000);
    idle();

    // mixed traffic
    for (int n = 0; n < 600; n++) begin
      logic [15:0] r;
      logic [15:0] op;
      int cat;
      r   = 16'($urandom);
      cat = int'($urandom % 6);
      case (cat)
        0: op = (r & 16'h07FF) | 16'h3800;
        1: op = (r & 16'h2CFF) | 16'h8300;
        2: op = (r & 16'h0EFF) | 16'h4100;
        3: op = (r & 16'h1EFF) | 16'h6100;
        4: op = (r & 16'h02FF) | 16'hB400;
        default: op = r;
      endcase
      if (n % 97 == 0) rf[n % 16] = $urandom;
      step(($urandom % 4) != 0, op, 16'($urandom), 16'($urandom), 16'($urandom), $urandom);
    end
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule